// File: doc/BRIEF.md
# Chroma Bilinear Interpolation Engine

This block produces fractional-position chroma prediction rows for a small reference block. The reference rows arrive one at a time as a wide bus. In each row the two chroma components are interleaved, so a byte's horizontal neighbour of the same component sits two bytes further along the bus. Both components are filtered together in one pass. A start pulse captures two 3-bit eighth-sample offsets and two size selectors. From these the engine forms four bilinear weights, which it keeps for the whole block.

The engine keeps the most recent input row. Each new row then pairs with the row before it to give one output row, so a block of N output rows takes N+1 input rows. Rows enter and leave through valid/ready handshakes. The controller has five states. IDLE waits for start. PRIME takes the first input row and moves to FILL. FILL takes the next row, computes and registers the output row, and moves to EMIT. EMIT holds the output until it is accepted. From EMIT the engine goes back to FILL if more rows remain, or to FINISH after the last row. FINISH raises done for one cycle and returns to IDLE.

Top module: `chroma_bilin_engine`

## Requirements
- R1: After reset, in_ready, out_valid and done are all low, and the engine sits idle.
- R2: On start in IDLE, the weights are captured from frac_x (dx) and frac_y (dy): A=(8-dx)(8-dy), B=dx(8-dy), C=(8-dx)dy, D=dx·dy. They total 64 and stay fixed for the whole block, whatever frac_x, frac_y, width_sel and height_sel do afterwards.
- R3: Output byte k of output row r is (A·u[k] + B·u[k+2] + C·l[k] + D·l[k+2] + 32) >> 6. Here u is input row r, l is input row r+1, and byte k of a row bus occupies bits [8k+7:8k].
- R4: Every output byte is limited to 255. Inputs that are all 255 give 255 for every offset.
- R5: width_sel selects the number of sample pairs: 0 gives 2, 1 gives 4, and 2 or 3 gives 8. An output row holds 2·pairs valid bytes, and the bytes above them read zero. Input bytes above index 2·pairs+1 have no effect.
- R6: height_sel selects the output rows: 0 gives 2, 1 gives 4, and 2 or 3 gives 8. A block accepts exactly height+1 input rows and sends exactly height output rows.
- R7: Each input row after the first is the lower row of one output and the upper row of the next.
- R8: in_ready is high only in PRIME and FILL, and never together with out_valid. While out_valid is high and out_ready is low, out_row holds still.
- R9: done is a one-cycle pulse in the cycle after the last output handshake. The engine is then idle.
- R10: A start pulse while a block is in progress has no effect on that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a block and latches its configuration (accepted in IDLE only) |
| frac_x | input | 3 | Horizontal eighth-sample offset |
| frac_y | input | 3 | Vertical eighth-sample offset |
| width_sel | input | 2 | Sample-pair count selector |
| height_sel | input | 2 | Output row count selector |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Engine accepts an input row |
| in_row | input | 144 | Input row, 18 interleaved bytes |
| out_valid | output | 1 | Output row present |
| out_ready | input | 1 | Consumer accepts the output row |
| out_row | output | 128 | Output row, 16 interleaved bytes |
| done | output | 1 | Block complete pulse |

## Verification
Every pair of offsets is swept with eight sample pairs. The row data rotates between random bytes, a row ramp, all zeros and all 255. Random data separates each of the four weights and the +2 neighbour step. The ramp shows whether the upper and lower rows have been swapped or reused wrongly. All-255 rows test saturation and rounding at the top of the range. Every combination of width and height selector is then run with random offsets and random bytes above the valid width, which checks zero fill, the ignored bytes and the row counts. The offset and size inputs are scrambled after start, and a stray start is pulsed during each block.

// File: rtl/chroma_bilin_pkg.sv
package chroma_bilin_pkg;
    localparam int SAMPLE_W  = 8;
    localparam int FRAC_W    = 3;
    localparam int MAX_PAIRS = 8;
    localparam int MAX_ROWS  = 8;
    localparam int WGT_W     = 2 * FRAC_W + 1;
    localparam int SHIFT     = 2 * FRAC_W;
    localparam int SUM_W     = SAMPLE_W + 2 * FRAC_W + 1;
    localparam int OUT_BYTES = 2 * MAX_PAIRS;
    localparam int IN_BYTES  = 2 * MAX_PAIRS + 2;
    localparam int PAIR_CW   = $clog2(MAX_PAIRS + 1);
    localparam int ROW_CW    = $clog2(MAX_ROWS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_FILL,
        ST_EMIT,
        ST_FINISH
    } eng_state_t;

    function automatic logic [PAIR_CW-1:0] pairs_of(input logic [1:0] sel);
        unique case (sel)
            2'd0:    pairs_of = PAIR_CW'(2);
            2'd1:    pairs_of = PAIR_CW'(4);
            default: pairs_of = PAIR_CW'(8);
        endcase
    endfunction

    function automatic logic [ROW_CW-1:0] rows_of(input logic [1:0] sel);
        unique case (sel)
            2'd0:    rows_of = ROW_CW'(2);
            2'd1:    rows_of = ROW_CW'(4);
            default: rows_of = ROW_CW'(8);
        endcase
    endfunction
endpackage

// File: rtl/chroma_weight_gen.sv
module chroma_weight_gen
    import chroma_bilin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FRAC_W-1:0] dx,
    input  logic [FRAC_W-1:0] dy,
    output logic [WGT_W-1:0]  w_a,
    output logic [WGT_W-1:0]  w_b,
    output logic [WGT_W-1:0]  w_c,
    output logic [WGT_W-1:0]  w_d
);
    localparam int ONE = 1 << FRAC_W;

    logic [WGT_W-1:0] inv_x, inv_y, ex, ey;

    always_comb begin
        ex    = WGT_W'(dx);
        ey    = WGT_W'(dy);
        inv_x = WGT_W'(ONE) - ex;
        inv_y = WGT_W'(ONE) - ey;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_a <= '0;
            w_b <= '0;
            w_c <= '0;
            w_d <= '0;
        end else if (load) begin
            w_a <= inv_x * inv_y;
            w_b <= ex * inv_y;
            w_c <= inv_x * ey;
            w_d <= ex * ey;
        end
    end
endmodule

// File: rtl/chroma_filter_lane.sv
module chroma_filter_lane
    import chroma_bilin_pkg::*;
(
    input  logic [WGT_W-1:0]    w_a,
    input  logic [WGT_W-1:0]    w_b,
    input  logic [WGT_W-1:0]    w_c,
    input  logic [WGT_W-1:0]    w_d,
    input  logic [SAMPLE_W-1:0] up_here,
    input  logic [SAMPLE_W-1:0] up_next,
    input  logic [SAMPLE_W-1:0] lo_here,
    input  logic [SAMPLE_W-1:0] lo_next,
    output logic [SAMPLE_W-1:0] result
);
    localparam logic [SUM_W-1:0] ROUND = SUM_W'(1) << (SHIFT - 1);
    localparam logic [SUM_W-1:0] SMAX  = SUM_W'((1 << SAMPLE_W) - 1);

    logic [SUM_W-1:0] acc, scaled;

    always_comb begin
        acc = SUM_W'(w_a) * SUM_W'(up_here)
            + SUM_W'(w_b) * SUM_W'(up_next)
            + SUM_W'(w_c) * SUM_W'(lo_here)
            + SUM_W'(w_d) * SUM_W'(lo_next)
            + ROUND;
        scaled = acc >> SHIFT;
        result = (scaled > SMAX) ? SMAX[SAMPLE_W-1:0] : scaled[SAMPLE_W-1:0];
    end
endmodule

// File: rtl/chroma_bilin_engine.sv
module chroma_bilin_engine
    import chroma_bilin_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [FRAC_W-1:0]             frac_x,
    input  logic [FRAC_W-1:0]             frac_y,
    input  logic [1:0]                    width_sel,
    input  logic [1:0]                    height_sel,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [IN_BYTES*SAMPLE_W-1:0]  in_row,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [OUT_BYTES*SAMPLE_W-1:0] out_row,
    output logic                          done
);
    eng_state_t state, state_nx;

    logic [PAIR_CW-1:0]            pairs_q;
    logic [ROW_CW-1:0]             rows_q;
    logic [ROW_CW-1:0]             row_idx;
    logic [IN_BYTES*SAMPLE_W-1:0]  upper_q;
    logic [OUT_BYTES*SAMPLE_W-1:0] lane_out;
    logic [WGT_W-1:0]              w_a, w_b, w_c, w_d;

    logic take_cfg, in_fire, out_fire, last_row;

    assign take_cfg = (state == ST_IDLE) && start;
    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign last_row = (row_idx == rows_q - ROW_CW'(1));

    chroma_weight_gen u_wgen (
        .clk  (clk),
        .rst_n(rst_n),
        .load (take_cfg),
        .dx   (frac_x),
        .dy   (frac_y),
        .w_a  (w_a),
        .w_b  (w_b),
        .w_c  (w_c),
        .w_d  (w_d)
    );

    for (genvar k = 0; k < OUT_BYTES; k++) begin : g_lane
        logic [SAMPLE_W-1:0] res;
        chroma_filter_lane u_lane (
            .w_a    (w_a),
            .w_b    (w_b),
            .w_c    (w_c),
            .w_d    (w_d),
            .up_here(upper_q[k*SAMPLE_W +: SAMPLE_W]),
            .up_next(upper_q[(k+2)*SAMPLE_W +: SAMPLE_W]),
            .lo_here(in_row[k*SAMPLE_W +: SAMPLE_W]),
            .lo_next(in_row[(k+2)*SAMPLE_W +: SAMPLE_W]),
            .result (res)
        );
        assign lane_out[k*SAMPLE_W +: SAMPLE_W] =
            (k < 2 * int'(pairs_q)) ? res : '0;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)    state_nx = ST_PRIME;
            ST_PRIME:  if (in_fire)  state_nx = ST_FILL;
            ST_FILL:   if (in_fire)  state_nx = ST_EMIT;
            ST_EMIT:   if (out_fire) state_nx = last_row ? ST_FINISH : ST_FILL;
            ST_FINISH:               state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_PRIME, ST_FILL: in_ready  = 1'b1;
            ST_EMIT:           out_valid = 1'b1;
            ST_FINISH:         done      = 1'b1;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pairs_q <= '0;
            rows_q  <= '0;
            row_idx <= '0;
            upper_q <= '0;
            out_row <= '0;
        end else begin
            if (take_cfg) begin
                pairs_q <= pairs_of(width_sel);
                rows_q  <= rows_of(height_sel);
                row_idx <= '0;
            end
            if (in_fire) upper_q <= in_row;
            if (in_fire && state == ST_FILL) out_row <= lane_out;
            if (out_fire) row_idx <= row_idx + ROW_CW'(1);
        end
    end

    // R8: input and output sides never open together
    p_excl_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R8: a stalled output row holds still
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

    // R9: done lasts a single cycle and leaves the engine idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !in_ready && !out_valid));

    // R2: captured weights always total 64 during a block
    p_wsum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> ((32'(w_a) + 32'(w_b) + 32'(w_c) + 32'(w_d)) == 32'd64));

    // R5: bytes above the selected width read zero
    p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_row >> (16 * int'(pairs_q))) == '0));

    // R10: configuration holds while busy
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(pairs_q) && $stable(rows_q)));
endmodule

// File: tb/tb_chroma_bilin_engine.sv
module tb_chroma_bilin_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   frac_x = '0, frac_y = '0;
    logic [1:0]   width_sel = '0, height_sel = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [143:0] in_row = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_row;
    logic         done;

    int checks = 0;
    int errors = 0;
    logic [7:0] rows [0:8][0:17];

    always #4 clk = ~clk;

    chroma_bilin_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .frac_x(frac_x), .frac_y(frac_y),
        .width_sel(width_sel), .height_sel(height_sel), .in_valid(in_valid),
        .in_ready(in_ready), .in_row(in_row), .out_valid(out_valid),
        .out_ready(out_ready), .out_row(out_row), .done(done)
    );

    task automatic check(input logic ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [143:0] pack_row(input int r);
        logic [143:0] v = '0;
        for (int k = 0; k < 18; k++) v[k*8 +: 8] = rows[r][k];
        return v;
    endfunction

    function automatic logic [127:0] expect_row(input int r, input int dx, input int dy,
                                                input int np);
        logic [127:0] v = '0;
        int a = (8-dx)*(8-dy), b = dx*(8-dy), c = (8-dx)*dy, d = dx*dy;
        for (int k = 0; k < 2*np; k++) begin
            int s = (a*rows[r][k] + b*rows[r][k+2] + c*rows[r+1][k] + d*rows[r+1][k+2] + 32) >> 6;
            if (s > 255) s = 255;
            v[k*8 +: 8] = 8'(s);
        end
        return v;
    endfunction

    task automatic feed(input int r);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_row   = pack_row(r);
        @(negedge clk);
        in_valid = 1'b0;
        in_row   = '1;
    endtask

    task automatic run_block(input int dx, input int dy, input int ws, input int hs,
                             input int mode);
        int np = (ws == 0) ? 2 : (ws == 1) ? 4 : 8;
        int nr = (hs == 0) ? 2 : (hs == 1) ? 4 : 8;
        for (int r = 0; r < 9; r++)
            for (int k = 0; k < 18; k++)
                case (mode)
                    0: rows[r][k] = 8'($urandom);
                    1: rows[r][k] = 8'hFF;
                    2: rows[r][k] = 8'h00;
                    default: rows[r][k] = 8'(r*37 + k*11);
                endcase
        @(negedge clk);
        start = 1'b1; frac_x = 3'(dx); frac_y = 3'(dy);
        width_sel = 2'(ws); height_sel = 2'(hs);
        @(negedge clk);
        start = 1'b0; frac_x = ~3'(dx); frac_y = 3'(dy + 3);
        width_sel = ~2'(ws); height_sel = ~2'(hs);
        feed(0);
        for (int r = 0; r < nr; r++) begin
            logic [127:0] snap, exp;
            if (r == 0) start = 1'b1;
            feed(r + 1);
            start = 1'b0;
            while (!out_valid) @(negedge clk);
            check(!in_ready, "R8 in_ready while output pending", 128'(in_ready), 128'd0);
            exp = expect_row(r, dx, dy, np);
            if (r % 2 == 1) begin
                snap = out_row;
                @(negedge clk);
                check(out_valid && out_row == snap, "R8 stalled output moved", out_row, snap);
            end
            out_ready = 1'b1;
            check(out_row == exp, $sformatf("R3/R4/R5/R7/R2/R10 row %0d dx %0d dy %0d w %0d",
                  r, dx, dy, np), out_row, exp);
            @(negedge clk);
            out_ready = 1'b0;
            if (r < nr - 1)
                check(!done, "R6 early done", 128'(done), 128'd0);
        end
        check(done, "R9 R6 done after last row", 128'(done), 128'd1);
        @(negedge clk);
        check(!done && !in_ready && !out_valid, "R9 idle after done",
              {125'd0, done, in_ready, out_valid}, 128'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!in_ready && !out_valid && !done, "R1 reset outputs",
              {125'd0, in_ready, out_valid, done}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!in_ready && !out_valid && !done, "R1 idle after reset",
              {125'd0, in_ready, out_valid, done}, 128'd0);
        for (int dx = 0; dx < 8; dx++)
            for (int dy = 0; dy < 8; dy++)
                run_block(dx, dy, 2, 0, (dx + dy) % 4);
        for (int ws = 0; ws < 4; ws++)
            for (int hs = 0; hs < 4; hs++)
                run_block(int'($urandom % 8), int'($urandom % 8), ws, hs, 0);
        run_block(7, 7, 0, 2, 1);
        run_block(0, 0, 1, 1, 3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule